// File: doc/BRIEF.md
# GPIO Interrupt Channel Selector

This block routes GPIO input lines onto a fixed set of eight interrupt outputs. Software picks, for each output channel, which GPIO line feeds it, whether the channel reacts to a level or to an edge, and which sense of that level or edge counts as active. Each GPIO line passes through a two-flop synchroniser before it is selected. A channel in level mode drives its output from the polarity-corrected synchronised level. A channel in edge mode emits a one-cycle pulse when that level goes from inactive to active. A channel reacts to only one edge direction, so sensing both edges of a pin takes two channels pointed at the same line with opposite polarity.

Configuration goes through a small register bus: a write strobe, a two-bit word index and 32-bit write data, with a combinational read port. Word 0 holds the mode bits: bit n is the edge-mode enable of channel n and bit 16+n its active-low flag. Word 1 holds the line selects of channels 0 to 3 and word 2 those of channels 4 to 7. The select of channel n is the byte at bit 8*(n mod 4). Word 3 is a glitch-filter setting that is stored and read back but acts on nothing. A select value that names no existing line (0xFF, or any value of at least NUM_LINES) parks the channel.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, words 1 and 2 read 0xFFFFFFFF and words 0 and 3 read 0, and every output is low.
- R2: A write to word 1 or 2 sets the selects of four channels. Channel n takes the byte at bits 8*(n mod 4) of word 1 for n < 4 and of word 2 for n ≥ 4. The word reads back as written.
- R3: A channel whose select is 0xFF (or any value ≥ NUM_LINES) keeps its output low, whatever its mode and polarity bits and whatever the GPIO lines do.
- R4: A channel in level mode (word 0 bit n = 0) drives its output to the selected line XOR its active-low flag (word 0 bit 16+n). A change on the line reaches the output after two rising clock edges.
- R5: A channel in edge mode (word 0 bit n = 1) pulses its output high for exactly one cycle. The pulse follows a rising edge of the line when bit 16+n is 0, or a falling edge when it is 1. The opposite edge does nothing, and the pulse appears at the same cycle as the level-mode change would.
- R6: Two channels in edge mode, selecting the same line with opposite active-low flags, together give one pulse for every transition of that line: the rising edge on one channel, the falling edge on the other.
- R7: A write that changes a channel's select byte, edge-mode bit or active-low flag primes that channel's edge history. The first sample taken under the new setting never produces a pulse, even when the synchronised line becomes active in the cycle the write lands.
- R8: In word 0, bits 8 to 15 and 24 to 31 read as zero, and writing ones to them changes no channel's behaviour.
- R9: Word 3 stores all 32 written bits and reads them back, and its value has no effect on any output.
- R10: Channels are independent: several channels may select the same line at once, and each follows its own mode and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | NUM_LINES | Asynchronous GPIO lines |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 2 | Word index (byte offset divided by 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at reg_word |
| irq_out | output | 8 | Per-channel interrupt outputs |

## Verification
Two events can land in the same cycle: a configuration write that changes a channel, and the synchronised arrival of an active edge on that channel's new line. A directed case raises a GPIO line so that its synchronised edge lands on the same clock edge as the write that points an edge-mode channel at that line. The bench expects no pulse then or later, because the write primes the edge history. The random phase mixes sparse line toggles with frequent reconfiguration writes, so the same collision happens many more times. There, every output is compared each cycle with a bench model that states the requirements in its own terms.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int NCH     = 8;
  localparam int SEL_W   = 8;
  localparam int POL_OFS = 16;
  localparam logic [SEL_W-1:0] PARK = '1;

  localparam logic [1:0] WI_MODE   = 2'd0;
  localparam logic [1:0] WI_SEL_LO = 2'd1;
  localparam logic [1:0] WI_SEL_HI = 2'd2;
  localparam logic [1:0] WI_FILT   = 2'd3;

  // word index that carries the select byte of channel ch
  function automatic logic [1:0] sel_word(input int ch);
    return (ch < 4) ? WI_SEL_LO : WI_SEL_HI;
  endfunction

  // bit offset of the select byte of channel ch inside its word
  function automatic int sel_base(input int ch);
    return SEL_W * (ch % 4);
  endfunction

  // assemble the readable image of the mode word
  function automatic logic [31:0] mode_image(input logic [NCH-1:0] edge_en,
                                             input logic [NCH-1:0] act_low);
    logic [31:0] w;
    w = '0;
    w[NCH-1:0] = edge_en;
    w[POL_OFS +: NCH] = act_low;
    return w;
  endfunction
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gir_regfile.sv
module gir_regfile
  import gir_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           word,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NCH-1:0]       edge_en,
  output logic [NCH-1:0]       act_low,
  output logic [NCH*SEL_W-1:0] sel_all,
  output logic [NCH-1:0]       cfg_chg
);
  logic [31:0] sel_lo_q, sel_hi_q, filt_q;
  logic [NCH-1:0] edge_q, low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q   <= '0;
      low_q    <= '0;
      sel_lo_q <= '1;
      sel_hi_q <= '1;
      filt_q   <= '0;
    end else if (we) begin
      case (word)
        WI_MODE: begin
          edge_q <= wdata[NCH-1:0];
          low_q  <= wdata[POL_OFS +: NCH];
        end
        WI_SEL_LO: sel_lo_q <= wdata;
        WI_SEL_HI: sel_hi_q <= wdata;
        default:   filt_q   <= wdata;
      endcase
    end
  end

  always_comb begin
    case (word)
      WI_MODE:   rdata = mode_image(edge_q, low_q);
      WI_SEL_LO: rdata = sel_lo_q;
      WI_SEL_HI: rdata = sel_hi_q;
      default:   rdata = filt_q;
    endcase
  end

  assign edge_en = edge_q;
  assign act_low = low_q;
  assign sel_all = {sel_hi_q, sel_lo_q};

  // a write that alters any setting of a channel flags it for one cycle
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cfg_chg[c] = 1'b0;
      if (we && word == WI_MODE &&
          (wdata[c] != edge_q[c] || wdata[POL_OFS + c] != low_q[c]))
        cfg_chg[c] = 1'b1;
      if (we && word == sel_word(c) &&
          wdata[sel_base(c) +: SEL_W] != sel_all[c*SEL_W +: SEL_W])
        cfg_chg[c] = 1'b1;
    end
  end

  a_r2_sel_lo_store: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == WI_SEL_LO) |=> (sel_lo_q == $past(wdata)));
  a_r2_sel_hi_store: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == WI_SEL_HI) |=> (sel_hi_q == $past(wdata)));
  a_r9_filter_store: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == WI_FILT) |=> (filt_q == $past(wdata)));
  a_r8_mode_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == WI_MODE) |=> (edge_q == $past(wdata[NCH-1:0]) &&
                                 low_q == $past(wdata[POL_OFS +: NCH])));
endmodule

// File: rtl/gir_channel.sv
module gir_channel
  import gir_pkg::*;
#(
  parameter int NUM_LINES = 255,
  localparam int TBL = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TBL-1:0]   lines,
  input  logic [SEL_W-1:0] sel,
  input  logic             edge_en,
  input  logic             act_low,
  input  logic             cfg_chg,
  output logic             irq_o
);
  logic parked, lvl, prev_q, rise_evt;

  assign parked   = (32'(sel) >= NUM_LINES);
  assign lvl      = parked ? 1'b0 : (lines[sel] ^ act_low);
  assign rise_evt = lvl & ~prev_q;

  // history: primed to 1 on reconfiguration so no false edge follows
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b1;
    else if (cfg_chg) prev_q <= 1'b1;
    else              prev_q <= lvl;
  end

  assign irq_o = edge_en ? rise_evt : lvl;

  a_r3_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == PARK) |-> !irq_o);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en && irq_o && !cfg_chg) |=> !irq_o);
  a_r7_primed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!edge_en || !irq_o));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int NUM_LINES = 255
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] gpio_in,
  input  logic                 reg_we,
  input  logic [1:0]           reg_word,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NCH-1:0]       irq_out
);
  localparam int TBL = 1 << SEL_W;
  localparam int PAD = TBL - NUM_LINES;

  logic [NUM_LINES-1:0]   gpio_sync;
  logic [TBL-1:0]         lines;
  logic [NCH-1:0]         edge_en, act_low, cfg_chg;
  logic [NCH*SEL_W-1:0]   sel_all;

  gir_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpio_sync)
  );

  assign lines = {{PAD{1'b0}}, gpio_sync};

  gir_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .word(reg_word),
    .wdata(reg_wdata), .rdata(reg_rdata), .edge_en(edge_en),
    .act_low(act_low), .sel_all(sel_all), .cfg_chg(cfg_chg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gir_channel #(.NUM_LINES(NUM_LINES)) u_ch (
      .clk(clk), .rst_n(rst_n), .lines(lines),
      .sel(sel_all[c*SEL_W +: SEL_W]), .edge_en(edge_en[c]),
      .act_low(act_low[c]), .cfg_chg(cfg_chg[c]), .irq_o(irq_out[c])
    );
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_out == '0));
endmodule

// File: tb/gpio_irq_router_test.sv
`timescale 1ns/1ps
module gpio_irq_router_test;
  localparam int LINES = 255;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LINES-1:0] gpio = '0;
  logic             we = 1'b0;
  logic [1:0]       word = 2'd0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [7:0]       irq;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_router #(.NUM_LINES(LINES)) uut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio), .reg_we(we),
    .reg_word(word), .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
  );

  // ---------------- reference model ----------------
  logic [LINES-1:0] m_a, m_b;
  logic [7:0] m_hist, m_edge, m_low;
  logic [7:0] m_sel [8];

  function automatic bit m_active(int c);
    if (m_sel[c] >= LINES) return 1'b0;
    return m_b[m_sel[c]] ^ m_low[c];
  endfunction

  function automatic bit m_expect(int c);
    if (m_edge[c]) return m_active(c) && !m_hist[c];
    return m_active(c);
  endfunction

  function automatic bit m_touch(int c);
    if (!we) return 1'b0;
    if (word == 2'd0)
      return (wdata[c] != m_edge[c]) || (wdata[16+c] != m_low[c]);
    if ((c < 4 && word == 2'd1) || (c >= 4 && word == 2'd2))
      return wdata[8*(c%4) +: 8] != m_sel[c];
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a <= '0; m_b <= '0; m_hist <= '1; m_edge <= '0; m_low <= '0;
      for (int c = 0; c < 8; c++) m_sel[c] <= 8'hFF;
    end else begin
      m_a <= gpio;
      m_b <= m_a;
      for (int c = 0; c < 8; c++) m_hist[c] <= m_touch(c) ? 1'b1 : m_active(c);
      if (we) begin
        case (word)
          2'd0: begin m_edge <= wdata[7:0]; m_low <= wdata[23:16]; end
          2'd1: for (int c = 0; c < 4; c++) m_sel[c] <= wdata[8*c +: 8];
          2'd2: for (int c = 0; c < 4; c++) m_sel[c+4] <= wdata[8*c +: 8];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model (R3 R4 R5 R7 R10)
  always @(negedge clk) begin
    if (chk_on) begin
      logic [7:0] e;
      for (int c = 0; c < 8; c++) e[c] = m_expect(c);
      checks++;
      if (irq !== e) begin
        errors++;
        $display("FAIL R4 R5 R7 model compare: irq=%h expected=%h", irq, e);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; word = w; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk);
    word = w;
    #0.5 d = rdata;
  endtask

  // counts high cycles of one output over n cycles, sampled at negedge
  task automatic count_pulses(input int c, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq[c]) cnt++;
    end
  endtask

  function automatic logic [7:0] pick_sel();
    int r = $urandom_range(0, 9);
    if (r == 0) return 8'hFF;
    if (r == 1) return 8'd254;
    return 8'($urandom_range(0, 31));
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 mode word", d, 32'h0);
    rd(2'd1, d); check("R1 select lo", d, 32'hFFFF_FFFF);
    rd(2'd2, d); check("R1 select hi", d, 32'hFFFF_FFFF);
    rd(2'd3, d); check("R1 filter", d, 32'h0);
    check("R1 outputs", {24'h0, irq}, 32'h0);
    chk_on = 1'b1;

    // R8 reserved bits; R3 parked channels stay quiet with any mode
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R8 reserved read zero", d, 32'h00FF_00FF);
    gpio[31:0] = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    check("R3 parked active-low", {24'h0, irq}, 32'h0);
    gpio[31:0] = 32'h0;
    repeat (4) @(negedge clk);
    check("R3 parked low line", {24'h0, irq}, 32'h0);

    // R9 filter word has no effect
    wr(2'd3, 32'hA5A5_1234);
    rd(2'd3, d); check("R9 filter readback", d, 32'hA5A5_1234);

    // R2 + R4 level mode, active-high on ch0..3 from lines 0..3
    wr(2'd0, 32'hFF00_FF00);          // reserved ones only: all level-high (R8)
    rd(2'd0, d); check("R8 reserved write ignored", d, 32'h0);
    wr(2'd1, 32'h0302_0100);
    rd(2'd1, d); check("R2 select lo readback", d, 32'h0302_0100);
    @(negedge clk);
    gpio[0] = 1'b1; gpio[2] = 1'b1;
    @(negedge clk);
    check("R4 one edge not yet", {24'h0, irq}, 32'h0);
    @(negedge clk);
    check("R4 level after two edges", {24'h0, irq}, 32'h05);
    wr(2'd0, 32'h0002_0000);           // ch1 active-low
    @(negedge clk);
    check("R4 active-low ch1", {24'h0, irq}, 32'h07);
    gpio[0] = 1'b0; gpio[2] = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 level falls", {24'h0, irq}, 32'h02);

    // R5 R6 R10 edge mode: ch4 rising, ch5 falling, both on line 10
    wr(2'd0, 32'h0020_0030);
    wr(2'd2, 32'hFFFF_0A0A);
    rd(2'd2, d); check("R2 select hi readback", d, 32'hFFFF_0A0A);
    repeat (3) @(negedge clk);
    gpio[10] = 1'b1;
    fork
      count_pulses(4, 8, n);
      begin : cnt5 int k; count_pulses(5, 8, k); check("R6 falling ch ignores rise", k, 0); end
    join
    check("R5 one pulse on rise", n, 1);
    gpio[10] = 1'b0;
    fork
      count_pulses(5, 8, n);
      begin : cnt4 int k; count_pulses(4, 8, k); check("R5 rising ch ignores fall", k, 0); end
    join
    check("R6 one pulse on fall", n, 1);
    check("R10 shared line", {31'h0, uut.irq_out[4] | uut.irq_out[5]}, 0);

    // R7 write collides with synchronised edge: ch6 edge rising, line 20
    wr(2'd0, 32'h0020_0070);
    @(negedge clk);
    gpio[20] = 1'b1;                   // lands in second stage at the write edge
    wr(2'd2, 32'hFF14_0A0A);
    count_pulses(6, 6, n);
    check("R7 no false edge", n, 0);
    gpio[20] = 1'b0;
    repeat (4) @(negedge clk);
    gpio[20] = 1'b1;
    count_pulses(6, 6, n);
    check("R7 real edge later", n, 1);

    // random phase: sparse toggles and frequent reconfiguration
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      gpio[31:0] = gpio[31:0] ^ ($urandom & $urandom & $urandom);
      if ($urandom_range(0, 5) == 0) begin
        int w = $urandom_range(0, 3);
        we = 1'b1;
        word = 2'(w);
        if (w == 1 || w == 2)
          wdata = {pick_sel(), pick_sel(), pick_sel(), pick_sel()};
        else
          wdata = $urandom;
      end else begin
        we = 1'b0;
      end
    end
    @(negedge clk);
    we = 1'b0;
    repeat (4) @(negedge clk);

    chk_on = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule